// File: doc/BRIEF.md
# Serial PCM Frame Timing Master

This block is the timing master of a synchronous serial audio port. From a fast system clock it makes a bit clock at a fixed division ratio and a frame sync once per frame. In each frame it exchanges one 8-bit companded sample in each direction. With the default parameters an 8.192 MHz system clock gives a 2.048 MHz bit clock and an 8 kHz frame of 256 bit periods.

The sync takes one of two shapes. In the short format it is a one-bit-period pulse in the bit period just before the data slot. In the long format it stays high across the whole data slot. Transmit data leaves MSB first on bit-clock rising edges. Receive data is taken on falling edges. The serial output pin is driven only during the slot and floats at all other times. Companding, control words and clock recovery are handled elsewhere.

All outputs are registered. Position 0 of the frame is the first data bit.

Top module: `pcm_frame_master`

## Requirements
- R1: `bclk_o` has a period of CLK_DIV system clocks. It is high for the first CLK_DIV/2 of them, and its rising edge marks the start of each bit period.
- R2: A frame lasts FRAME_BITS bit periods, numbered 0 to FRAME_BITS-1. The data slot is bit periods 0 to SLOT_BITS-1, and the frame then wraps back to bit period 0.
- R3: In the short format (format select 0), `sync_o` is high for exactly bit period FRAME_BITS-1 and low for the rest of the frame.
- R4: In the long format (format select 1), `sync_o` is high for bit periods 0 to SLOT_BITS-1 and low for the rest of the frame.
- R5: `sdo_oe_o` is 1 during bit periods 0 to SLOT_BITS-1 and 0 otherwise. While it is 0, `sdo_o` is 0.
- R6: In bit period k of the slot, `sdo_o` carries bit SLOT_BITS-1-k of the transmit word, so the MSB goes first. The transmit word is the value of `tx_data_i` captured at the system edge that starts bit period 0. `sdo_o` changes only together with a `bclk_o` rising edge.
- R7: `sdi_i` is sampled at the system edge where `bclk_o` falls, once in each slot bit period. The first sample becomes the MSB of the received word.
- R8: `rx_valid_o` is high for exactly one system clock. That clock follows the falling edge that ends slot bit SLOT_BITS-1. `rx_data_o` then presents the received word and holds it until the next strobe.
- R9: While `rst_i` is high, at every clock edge, all outputs go to 0. The first edge after reset is released begins bit period 0 of a new frame, and `bclk_o` rises at that edge.
- R10: `sdi_i` outside the sampling edges of R7, and `tx_data_i` outside its capture edge, have no effect on any output.
- R11: The format select is sampled once per frame, at the edge that starts bit period 0. That value shapes `sync_o` for the whole frame, including the short pulse in bit period FRAME_BITS-1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_i | input | 1 | Synchronous active-high reset |
| fmt_long_i | input | 1 | Frame format select: 0 short pulse, 1 long pulse |
| sdi_i | input | 1 | Serial receive data |
| tx_data_i | input | SLOT_BITS | Sample to transmit in the next slot |
| bclk_o | output | 1 | Bit clock |
| sync_o | output | 1 | Frame sync |
| sdo_o | output | 1 | Serial transmit data |
| sdo_oe_o | output | 1 | Drive enable for the serial transmit pad (0 = float) |
| rx_data_o | output | SLOT_BITS | Last received sample |
| rx_valid_o | output | 1 | One-cycle strobe for a new received sample |

## Verification
The bench builds the block with CLK_DIV=4, SLOT_BITS=8 and FRAME_BITS shortened to 16. At that size a full frame wraps every 64 system clocks, so dozens of frames fit in a short run. Those frames cover short-only, long-only and frame-by-frame random format selection. Transmit and receive data change on every cycle, which puts the capture and sampling edges and the ignored inputs to the test in every frame. A reset in the middle of a frame checks the restart at bit period 0.

// File: rtl/pcm_frame_pkg.sv
package pcm_frame_pkg;

    typedef enum logic {
        FMT_SHORT = 1'b0,
        FMT_LONG  = 1'b1
    } sync_fmt_e;

    // Per-cycle position events decoded from the frame counters
    typedef struct packed {
        logic bit_rise;     // bclk rises at this edge
        logic bit_fall;     // bclk falls at this edge
        logic frame_start;  // first edge of bit period 0
        logic in_slot;      // current bit period is a data bit
        logic slot_last;    // current bit period is the last data bit
    } tick_s;

    function automatic logic sync_level(sync_fmt_e fmt, logic in_slot, logic pre_slot);
        return (fmt == FMT_LONG) ? in_slot : pre_slot;
    endfunction

endpackage

// File: rtl/pcm_timebase.sv
module pcm_timebase
    import pcm_frame_pkg::*;
#(
    parameter int CLK_DIV    = 4,
    parameter int FRAME_BITS = 256,
    parameter int SLOT_BITS  = 8
) (
    input  logic      clk_i,
    input  logic      rst_i,
    input  logic      fmt_long_i,
    output tick_s     tick_o,
    output logic      bclk_o,
    output logic      sync_o
);
    localparam int PH_W = $clog2(CLK_DIV);
    localparam int BC_W = $clog2(FRAME_BITS);
    localparam logic [PH_W-1:0] PH_LAST  = PH_W'(CLK_DIV - 1);
    localparam logic [PH_W-1:0] PH_HALF  = PH_W'(CLK_DIV / 2);
    localparam logic [BC_W-1:0] BC_LAST  = BC_W'(FRAME_BITS - 1);
    localparam logic [BC_W-1:0] SLOT_END = BC_W'(SLOT_BITS);
    localparam logic [BC_W-1:0] SLOT_TOP = BC_W'(SLOT_BITS - 1);

    logic [PH_W-1:0] ph;
    logic [BC_W-1:0] bcnt;
    sync_fmt_e       fmt_q;
    sync_fmt_e       fmt_eff;
    logic            pre_slot;

    always_comb begin
        tick_o.bit_rise    = (ph == '0);
        tick_o.bit_fall    = (ph == PH_HALF);
        tick_o.frame_start = (ph == '0) && (bcnt == '0);
        tick_o.in_slot     = (bcnt < SLOT_END);
        tick_o.slot_last   = (bcnt == SLOT_TOP);
        pre_slot           = (bcnt == BC_LAST);
        fmt_eff            = tick_o.frame_start ? sync_fmt_e'(fmt_long_i) : fmt_q;
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            ph     <= '0;
            bcnt   <= '0;
            fmt_q  <= FMT_SHORT;
            bclk_o <= 1'b0;
            sync_o <= 1'b0;
        end else begin
            if (ph == PH_LAST) begin
                ph   <= '0;
                bcnt <= (bcnt == BC_LAST) ? '0 : bcnt + 1'b1;
            end else begin
                ph <= ph + 1'b1;
            end
            if (tick_o.frame_start)
                fmt_q <= fmt_eff;
            bclk_o <= (ph < PH_HALF);
            sync_o <= sync_level(fmt_eff, tick_o.in_slot, pre_slot);
        end
    end

    // R1: phase counter advances by one inside a bit period
    a_r1_phase_step: assert property (@(posedge clk_i) disable iff (rst_i)
        (ph != PH_LAST) |=> (ph == PH_W'($past(ph) + 1'b1)));

    // R2: frame wraps to bit period 0 after the last bit period
    a_r2_frame_wrap: assert property (@(posedge clk_i) disable iff (rst_i)
        (ph == PH_LAST && bcnt == BC_LAST) |=> (ph == '0 && bcnt == '0));

    // R11: format held steady between frame starts
    a_r11_fmt_hold: assert property (@(posedge clk_i) disable iff (rst_i)
        !tick_o.frame_start |=> $stable(fmt_q));

endmodule

// File: rtl/pcm_tx_slot.sv
module pcm_tx_slot #(
    parameter int SLOT_BITS = 8
) (
    input  logic                 clk_i,
    input  logic                 rst_i,
    input  logic                 bit_rise_i,
    input  logic                 frame_start_i,
    input  logic                 in_slot_i,
    input  logic [SLOT_BITS-1:0] tx_data_i,
    output logic                 sdo_o,
    output logic                 sdo_oe_o
);
    logic [SLOT_BITS-1:0] sh;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            sh       <= '0;
            sdo_o    <= 1'b0;
            sdo_oe_o <= 1'b0;
        end else if (bit_rise_i) begin
            if (frame_start_i) begin
                sdo_o    <= tx_data_i[SLOT_BITS-1];
                sh       <= {tx_data_i[SLOT_BITS-2:0], 1'b0};
                sdo_oe_o <= 1'b1;
            end else if (in_slot_i) begin
                sdo_o    <= sh[SLOT_BITS-1];
                sh       <= {sh[SLOT_BITS-2:0], 1'b0};
                sdo_oe_o <= 1'b1;
            end else begin
                sdo_o    <= 1'b0;
                sdo_oe_o <= 1'b0;
            end
        end
    end

    // R5: data line quiet while the pad floats
    a_r5_quiet_when_off: assert property (@(posedge clk_i) disable iff (rst_i)
        !sdo_oe_o |-> !sdo_o);

endmodule

// File: rtl/pcm_rx_slot.sv
module pcm_rx_slot #(
    parameter int SLOT_BITS = 8
) (
    input  logic                 clk_i,
    input  logic                 rst_i,
    input  logic                 bit_fall_i,
    input  logic                 in_slot_i,
    input  logic                 slot_last_i,
    input  logic                 sdi_i,
    output logic [SLOT_BITS-1:0] rx_data_o,
    output logic                 rx_valid_o
);
    logic [SLOT_BITS-1:0] rsh;
    logic [SLOT_BITS-1:0] rsh_next;

    assign rsh_next = {rsh[SLOT_BITS-2:0], sdi_i};

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            rsh        <= '0;
            rx_data_o  <= '0;
            rx_valid_o <= 1'b0;
        end else begin
            rx_valid_o <= 1'b0;
            if (bit_fall_i && in_slot_i) begin
                rsh <= rsh_next;
                if (slot_last_i) begin
                    rx_data_o  <= rsh_next;
                    rx_valid_o <= 1'b1;
                end
            end
        end
    end

    // R8: strobe lasts one clock
    a_r8_valid_pulse: assert property (@(posedge clk_i) disable iff (rst_i)
        rx_valid_o |=> !rx_valid_o);

    // R8: received word held between strobes
    a_r8_rx_hold: assert property (@(posedge clk_i) disable iff (rst_i)
        !rx_valid_o |-> $stable(rx_data_o));

endmodule

// File: rtl/pcm_frame_master.sv
module pcm_frame_master
    import pcm_frame_pkg::*;
#(
    parameter int CLK_DIV    = 4,
    parameter int FRAME_BITS = 256,
    parameter int SLOT_BITS  = 8
) (
    input  logic                 clk_i,
    input  logic                 rst_i,
    input  logic                 fmt_long_i,
    input  logic                 sdi_i,
    input  logic [SLOT_BITS-1:0] tx_data_i,
    output logic                 bclk_o,
    output logic                 sync_o,
    output logic                 sdo_o,
    output logic                 sdo_oe_o,
    output logic [SLOT_BITS-1:0] rx_data_o,
    output logic                 rx_valid_o
);
    tick_s tick;

    pcm_timebase #(
        .CLK_DIV    (CLK_DIV),
        .FRAME_BITS (FRAME_BITS),
        .SLOT_BITS  (SLOT_BITS)
    ) u_timebase (
        .clk_i      (clk_i),
        .rst_i      (rst_i),
        .fmt_long_i (fmt_long_i),
        .tick_o     (tick),
        .bclk_o     (bclk_o),
        .sync_o     (sync_o)
    );

    pcm_tx_slot #(
        .SLOT_BITS (SLOT_BITS)
    ) u_tx (
        .clk_i         (clk_i),
        .rst_i         (rst_i),
        .bit_rise_i    (tick.bit_rise),
        .frame_start_i (tick.frame_start),
        .in_slot_i     (tick.in_slot),
        .tx_data_i     (tx_data_i),
        .sdo_o         (sdo_o),
        .sdo_oe_o      (sdo_oe_o)
    );

    pcm_rx_slot #(
        .SLOT_BITS (SLOT_BITS)
    ) u_rx (
        .clk_i       (clk_i),
        .rst_i       (rst_i),
        .bit_fall_i  (tick.bit_fall),
        .in_slot_i   (tick.in_slot),
        .slot_last_i (tick.slot_last),
        .sdi_i       (sdi_i),
        .rx_data_o   (rx_data_o),
        .rx_valid_o  (rx_valid_o)
    );

    // R3 / R4: sync edges only coincide with bclk rising edges
    a_r3_sync_on_rise: assert property (@(posedge clk_i) disable iff (rst_i)
        !$stable(sync_o) |-> $rose(bclk_o));

    // R5: pad drive starts on a bclk rising edge
    a_r5_oe_on_rise: assert property (@(posedge clk_i) disable iff (rst_i)
        $rose(sdo_oe_o) |-> $rose(bclk_o));

    // R6: driven data changes only with bclk rising
    a_r6_sdo_on_rise: assert property (@(posedge clk_i) disable iff (rst_i)
        (sdo_oe_o && $past(sdo_oe_o) && !$stable(sdo_o)) |-> $rose(bclk_o));

    // R7 / R8: strobe follows a bclk falling edge
    a_r7_valid_on_fall: assert property (@(posedge clk_i) disable iff (rst_i)
        $rose(rx_valid_o) |-> $fell(bclk_o));

endmodule

// File: tb/test_pcm_frame_master.sv
`timescale 1ns/1ps
module test_pcm_frame_master;
    localparam int D = 4;
    localparam int F = 16;
    localparam int S = 8;
    localparam int H = D / 2;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         fmt = 1'b0;
    logic         sdi = 1'b0;
    logic [S-1:0] tx  = '0;
    logic         bclk, sync, sdo, sdo_oe, rx_valid;
    logic [S-1:0] rx_data;

    always #2 clk = ~clk;

    pcm_frame_master #(
        .CLK_DIV    (D),
        .FRAME_BITS (F),
        .SLOT_BITS  (S)
    ) i_pcm_frame_master (
        .clk_i      (clk),
        .rst_i      (rst),
        .fmt_long_i (fmt),
        .sdi_i      (sdi),
        .tx_data_i  (tx),
        .bclk_o     (bclk),
        .sync_o     (sync),
        .sdo_o      (sdo),
        .sdo_oe_o   (sdo_oe),
        .rx_data_o  (rx_data),
        .rx_valid_o (rx_valid)
    );

    int           n_checks = 0;
    int           n_fail   = 0;
    bit           done     = 0;
    int           pos      = 0;
    logic [S-1:0] txlat    = '0;
    logic [S-1:0] rxacc    = '0;
    logic [S-1:0] rxlast   = '0;
    logic         fmtlat   = 1'b0;

    task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s at pos %0d: actual=%0h expected=%0h", tag, what, pos, act, exp);
        end
    endtask

    // R9: all outputs cleared while reset is held, restart at position 0
    task automatic reset_cycles(int k);
        for (int i = 0; i < k; i++) begin
            rst = 1'b1;
            tx  = S'($urandom);
            sdi = 1'($urandom);
            @(posedge clk);
            @(negedge clk);
            chk("R9", "bclk",     bclk,     0);
            chk("R9", "sync",     sync,     0);
            chk("R9", "sdo_oe",   sdo_oe,   0);
            chk("R9", "sdo",      sdo,      0);
            chk("R9", "rx_valid", rx_valid, 0);
            chk("R9", "rx_data",  rx_data,  0);
        end
        pos    = 0;
        rxlast = '0;
    endtask

    // fmt_mode: 0 short, 1 long, 2 random every cycle
    task automatic run(int cycles, int fmt_mode);
        for (int i = 0; i < cycles; i++) begin
            int  ph;
            int  b;
            bit  ev;
            rst = 1'b0;
            tx  = S'($urandom);
            sdi = 1'($urandom);
            fmt = (fmt_mode == 2) ? 1'($urandom) : 1'(fmt_mode);
            ph  = pos % D;
            b   = (pos / D) % F;
            @(posedge clk);
            if (ph == 0 && b == 0) begin
                txlat  = tx;
                fmtlat = fmt;
            end
            if (ph == H && b < S)
                rxacc = {rxacc[S-2:0], sdi};
            ev = (ph == H && b == S - 1);
            if (ev)
                rxlast = rxacc;
            pos++;
            @(negedge clk);
            chk("R1", "bclk", bclk, (ph < H));
            chk(fmtlat ? "R4 R11" : "R3 R11", "sync", sync,
                fmtlat ? (b < S) : (b == F - 1));
            chk("R2 R5", "sdo_oe", sdo_oe, (b < S));
            chk("R6 R10", "sdo", sdo, (b < S) ? txlat[S-1-b] : 1'b0);
            chk("R8", "rx_valid", rx_valid, ev);
            chk("R7 R10", "rx_data", rx_data, rxlast);
        end
    endtask

    initial begin
        reset_cycles(4);
        run(64 * 6, 0);
        run(64 * 6, 1);
        run(64 * 3 + 23, 2);
        reset_cycles(3);
        run(64 * 12, 2);
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        #(200000 * 4);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired before the run completed");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

endmodule